// File: doc/BRIEF.md
# Program Memory Lock Guard

This block turns three one-way lock bits into the permission signals that protect a microcontroller's internal program memory. The lock bits are loaded from their nonvolatile copy while reset is held. After that they can be raised by a lock write, but never lowered, except by a full chip erase that drops all of them at once. A higher lock level always carries every restriction of the levels below it.

From the lock state the block derives its permissions. One stops table-lookup (MOVC) reads that run from external program memory from reading internal code. The others control flash programming, flash verify reads and execution from external memory. Code and verify reads from the flash array pass through a one-stage gate. A refused read returns all ones and raises a one-cycle violation pulse.

While reset is held and the first lock bit is programmed, the external-access pin is sampled. The captured level then replaces the live pin for the rest of the run. A flag shows when the pin later disagrees with the captured level.

Top module: `codelock_guard`

## Requirements
- R1: While `rst_n` is low, the lock state is loaded from `nv_lock`, `rd_valid` and `rd_violation` are 0 and `rd_data` is 0. A lock bit value of 1 means programmed.
- R2: A lock write (`lock_wr_en` high) programs every bit that is 1 in `lock_wr_data` from the next clock edge on. Bits that are 0 in the write are ignored, so a write can never return a programmed bit to unprogrammed.
- R3: `chip_erase` clears all three lock bits at the next edge and takes priority over a lock write in the same cycle.
- R4: `lock_level` is the index plus one of the highest programmed bit: 0 none, 1 for bit 0 only, 2 when bit 1 is the highest, 3 when bit 2 is programmed.
- R5: Any programmed lock bit drives `prog_allow` low and refuses MOVC reads (`rd_verify`=0) issued with `rd_pc_ext`=1. A MOVC read with `rd_pc_ext`=0 is never refused.
- R6: When bit 1 or bit 2 is programmed, `verify_allow` is 0 and verify reads (`rd_verify`=1) are refused.
- R7: When bit 2 is programmed, `ext_exec_allow` is 0.
- R8: One cycle after `rd_req`, `rd_valid` is 1. `rd_data` then equals the `flash_rdata` sampled with the request if the read is allowed, or 0xFF with `rd_violation` high if it is refused. The violation lasts one cycle per refused request.
- R9: If `nv_lock` bit 0 is 1 during reset, `ea_pin` is captured during reset and `ea_eff` holds that value after reset. Otherwise, `ea_eff` follows `ea_pin`, even if bit 0 is programmed later.
- R10: `ea_mismatch` is 1 exactly when a captured value is in use and it differs from the live `ea_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nv_lock | input | 3 | Nonvolatile lock bit copy, loaded during reset |
| lock_wr_en | input | 1 | Lock write strobe |
| lock_wr_data | input | 3 | Bits to program (1 = program) |
| chip_erase | input | 1 | Full chip erase, clears all lock bits |
| ea_pin | input | 1 | Live external-access pin level |
| rd_req | input | 1 | Internal code read request |
| rd_verify | input | 1 | 1 = verify read, 0 = MOVC read |
| rd_pc_ext | input | 1 | Requesting instruction runs from external memory |
| flash_rdata | input | 8 | Byte returned by the flash array for this request |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result byte |
| rd_violation | output | 1 | One-cycle pulse for a refused read |
| prog_allow | output | 1 | Flash programming permitted |
| verify_allow | output | 1 | Flash verify permitted |
| ext_exec_allow | output | 1 | Execution from external memory permitted |
| lock_level | output | 2 | Current protection level |
| ea_eff | output | 1 | External-access level used by the core |
| ea_mismatch | output | 1 | Captured level differs from live pin |

## Verification
The permission outputs and `lock_level` are combinational in the lock state. They are due in the cycle after the lock write or erase edge, so the bench samples them at the falling edge that follows that rising edge. Read results come one register later. The bench drops `rd_req` and checks `rd_data`, `rd_valid` and `rd_violation` at the falling edge that follows the capturing rising edge. One cycle after that, it confirms that the violation pulse has ended. The EA results are checked in the first cycle after reset release and again after the live pin moves.

// File: rtl/codelock_pkg.sv
package codelock_pkg;
   // index of the lock bit whose programming enables each restriction
   localparam int unsigned IDX_CODE   = 0;
   localparam int unsigned IDX_VERIFY = 1;
   localparam int unsigned IDX_EXTRUN = 2;
   localparam int unsigned MIN_BITS   = 3;

   typedef struct packed {
      logic movc_ok;
      logic prog_ok;
      logic verify_ok;
      logic extrun_ok;
   } perm_t;
endpackage

// File: rtl/codelock_store.sv
module codelock_store #(
   parameter int unsigned LOCK_BITS = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LOCK_BITS-1:0] nv_lock,
   input  logic                 wr_en,
   input  logic [LOCK_BITS-1:0] wr_data,
   input  logic                 erase,
   output logic [LOCK_BITS-1:0] lock_q
);
   for (genvar g = 0; g < LOCK_BITS; g++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            lock_q[g] <= nv_lock[g];
         else if (erase)
            lock_q[g] <= 1'b0;
         else if (wr_en && wr_data[g])
            lock_q[g] <= 1'b1;
      end
   end

   // R2: without an erase no bit ever falls
   p_no_unprogram_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !erase |=> (($past(lock_q) & ~lock_q) == '0));
   // R3: an erase leaves every bit cleared
   p_erase_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      erase |=> (lock_q == '0));
endmodule

// File: rtl/codelock_policy.sv
module codelock_policy
   import codelock_pkg::*;
#(
   parameter int unsigned LOCK_BITS = 3,
   parameter int unsigned LVL_W     = $clog2(LOCK_BITS + 1)
) (
   input  logic [LOCK_BITS-1:0] lock_q,
   output perm_t                perm,
   output logic [LVL_W-1:0]     level
);
   // reach[i] = some bit at index i or above is programmed
   logic [LOCK_BITS-1:0] reach;

   for (genvar g = 0; g < LOCK_BITS; g++) begin : g_reach
      assign reach[g] = |lock_q[LOCK_BITS-1:g];
   end

   always_comb begin
      level = '0;
      for (int i = 0; i < LOCK_BITS; i++)
         if (lock_q[i]) level = LVL_W'(i + 1);
   end

   always_comb begin
      perm.movc_ok   = ~reach[IDX_CODE];
      perm.prog_ok   = ~reach[IDX_CODE];
      perm.verify_ok = ~reach[IDX_VERIFY];
      perm.extrun_ok = ~reach[IDX_EXTRUN];
   end
endmodule

// File: rtl/codelock_ea.sv
module codelock_ea #(
   parameter bit CAPTURE_ON_LB1 = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lb1_at_reset,
   input  logic ea_pin,
   output logic ea_eff,
   output logic ea_mismatch
);
   logic use_cap;
   logic ea_cap;

   always_ff @(posedge clk) begin
      if (!rst_n) use_cap <= CAPTURE_ON_LB1 & lb1_at_reset;
   end

   // no reset value: undefined until the first reset samples the pin
   always_ff @(posedge clk) begin
      if (!rst_n && lb1_at_reset) ea_cap <= ea_pin;
   end

   assign ea_eff      = use_cap ? ea_cap : ea_pin;
   assign ea_mismatch = use_cap & (ea_cap ^ ea_pin);

   // R9: captured level never moves outside reset
   p_cap_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      use_cap |=> $stable(ea_eff));
   // R10: a mismatch is visible between effective level and pin
   p_mismatch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ea_mismatch |-> (ea_eff != ea_pin));
endmodule

// File: rtl/codelock_rdgate.sv
module codelock_rdgate
   import codelock_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] FILL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  perm_t             perm,
   input  logic              rd_req,
   input  logic              rd_verify,
   input  logic              rd_pc_ext,
   input  logic [DATA_W-1:0] flash_rdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_violation
);
   logic refuse;

   always_comb begin
      if (rd_verify) refuse = ~perm.verify_ok;
      else           refuse = rd_pc_ext & ~perm.movc_ok;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid     <= 1'b0;
         rd_data      <= '0;
         rd_violation <= 1'b0;
      end else begin
         rd_valid     <= rd_req;
         rd_violation <= rd_req & refuse;
         if (rd_req) rd_data <= refuse ? FILL : flash_rdata;
      end
   end

   // R6: refused verify read returns fill with a violation
   p_verify_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_verify && !perm.verify_ok) |=> (rd_violation && rd_data == FILL));
   // R5: internal MOVC reads are never refused
   p_movc_int_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_verify && !rd_pc_ext) |=> !rd_violation);
   // R8: a violation always comes with a valid result
   p_viol_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_violation |-> rd_valid);
endmodule

// File: rtl/codelock_guard.sv
module codelock_guard
   import codelock_pkg::*;
#(
   parameter int unsigned LOCK_BITS = 3,
   parameter int unsigned DATA_W    = 8,
   parameter bit          CAPTURE_ON_LB1 = 1'b1,
   parameter int unsigned LVL_W     = $clog2(LOCK_BITS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LOCK_BITS-1:0] nv_lock,
   input  logic                 lock_wr_en,
   input  logic [LOCK_BITS-1:0] lock_wr_data,
   input  logic                 chip_erase,
   input  logic                 ea_pin,
   input  logic                 rd_req,
   input  logic                 rd_verify,
   input  logic                 rd_pc_ext,
   input  logic [DATA_W-1:0]    flash_rdata,
   output logic                 rd_valid,
   output logic [DATA_W-1:0]    rd_data,
   output logic                 rd_violation,
   output logic                 prog_allow,
   output logic                 verify_allow,
   output logic                 ext_exec_allow,
   output logic [LVL_W-1:0]     lock_level,
   output logic                 ea_eff,
   output logic                 ea_mismatch
);
   localparam logic [DATA_W-1:0] FILL = '1;

   if (LOCK_BITS != MIN_BITS) begin : g_bad_bits
      $error("codelock_guard: LOCK_BITS must be 3");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("codelock_guard: DATA_W must be positive");
   end

   logic [LOCK_BITS-1:0] lock_q;
   perm_t                perm;

   codelock_store #(.LOCK_BITS(LOCK_BITS)) u_store (
      .clk(clk), .rst_n(rst_n), .nv_lock(nv_lock),
      .wr_en(lock_wr_en), .wr_data(lock_wr_data),
      .erase(chip_erase), .lock_q(lock_q)
   );

   codelock_policy #(.LOCK_BITS(LOCK_BITS), .LVL_W(LVL_W)) u_policy (
      .lock_q(lock_q), .perm(perm), .level(lock_level)
   );

   codelock_ea #(.CAPTURE_ON_LB1(CAPTURE_ON_LB1)) u_ea (
      .clk(clk), .rst_n(rst_n), .lb1_at_reset(nv_lock[IDX_CODE]),
      .ea_pin(ea_pin), .ea_eff(ea_eff), .ea_mismatch(ea_mismatch)
   );

   codelock_rdgate #(.DATA_W(DATA_W), .FILL(FILL)) u_rdgate (
      .clk(clk), .rst_n(rst_n), .perm(perm),
      .rd_req(rd_req), .rd_verify(rd_verify), .rd_pc_ext(rd_pc_ext),
      .flash_rdata(flash_rdata), .rd_valid(rd_valid),
      .rd_data(rd_data), .rd_violation(rd_violation)
   );

   assign prog_allow     = perm.prog_ok;
   assign verify_allow   = perm.verify_ok;
   assign ext_exec_allow = perm.extrun_ok;

   // R7: levels accumulate, external run blocked implies verify blocked
   p_ext_implies_verify_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_exec_allow |-> !verify_allow);
   // R6: verify blocked implies programming blocked
   p_verify_implies_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !verify_allow |-> !prog_allow);
   // R4: level 0 exactly when programming is allowed
   p_level_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_level == '0) == prog_allow);
endmodule

// File: tb/sim_codelock_guard.sv
module sim_codelock_guard;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] nv_lock = 3'b000;
   logic       lock_wr_en = 1'b0;
   logic [2:0] lock_wr_data = 3'b000;
   logic       chip_erase = 1'b0;
   logic       ea_pin = 1'b0;
   logic       rd_req = 1'b0;
   logic       rd_verify = 1'b0;
   logic       rd_pc_ext = 1'b0;
   logic [7:0] flash_rdata = 8'h00;
   logic       rd_valid, rd_violation, prog_allow, verify_allow, ext_exec_allow;
   logic       ea_eff, ea_mismatch;
   logic [7:0] rd_data;
   logic [1:0] lock_level;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   codelock_guard u0 (
      .clk(clk), .rst_n(rst_n), .nv_lock(nv_lock), .lock_wr_en(lock_wr_en),
      .lock_wr_data(lock_wr_data), .chip_erase(chip_erase), .ea_pin(ea_pin),
      .rd_req(rd_req), .rd_verify(rd_verify), .rd_pc_ext(rd_pc_ext),
      .flash_rdata(flash_rdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_violation(rd_violation), .prog_allow(prog_allow),
      .verify_allow(verify_allow), .ext_exec_allow(ext_exec_allow),
      .lock_level(lock_level), .ea_eff(ea_eff), .ea_mismatch(ea_mismatch)
   );

   // {lock[2:0], verify, pc_ext, flash byte, expected byte, expected violation}
   localparam int NV = 12;
   localparam logic [21:0] VEC [NV] = '{
      {3'b000, 1'b0, 1'b1, 8'h5A, 8'h5A, 1'b0},
      {3'b001, 1'b0, 1'b1, 8'h5A, 8'hFF, 1'b1},
      {3'b001, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b0},
      {3'b001, 1'b1, 1'b0, 8'h77, 8'h77, 1'b0},
      {3'b011, 1'b1, 1'b1, 8'h77, 8'hFF, 1'b1},
      {3'b011, 1'b0, 1'b1, 8'h12, 8'hFF, 1'b1},
      {3'b111, 1'b1, 1'b0, 8'h81, 8'hFF, 1'b1},
      {3'b111, 1'b0, 1'b0, 8'h81, 8'h81, 1'b0},
      {3'b010, 1'b1, 1'b0, 8'h44, 8'hFF, 1'b1},
      {3'b100, 1'b0, 1'b1, 8'h44, 8'hFF, 1'b1},
      {3'b000, 1'b1, 1'b1, 8'hC3, 8'hC3, 1'b0},
      {3'b100, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b1}
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_level(input logic [2:0] b);
      return b[2] ? 3 : (b[1] ? 2 : (b[0] ? 1 : 0));
   endfunction

   task automatic do_reset(input logic [2:0] nv, input logic ea);
      @(negedge clk);
      nv_lock = nv; ea_pin = ea; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic load_lock(input logic [2:0] b);
      chip_erase = 1'b1;
      @(negedge clk);
      chip_erase = 1'b0; lock_wr_en = 1'b1; lock_wr_data = b;
      @(negedge clk);
      lock_wr_en = 1'b0; lock_wr_data = 3'b000;
   endtask

   task automatic check_perm(input logic [2:0] b);
      check("R4 lock_level", int'(lock_level), exp_level(b));
      check("R5 prog_allow", int'(prog_allow), int'(b == 3'b000));
      check("R6 verify_allow", int'(verify_allow), int'(b[2:1] == 2'b00));
      check("R7 ext_exec_allow", int'(ext_exec_allow), int'(!b[2]));
   endtask

   initial begin
      // R1: reset state
      nv_lock = 3'b000; ea_pin = 1'b0; rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 rd_valid in reset", int'(rd_valid), 0);
      check("R1 rd_violation in reset", int'(rd_violation), 0);
      check("R1 rd_data in reset", int'(rd_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_perm(3'b000);

      // table walk: R5 R6 R7 R8
      for (int i = 0; i < NV; i++) begin
         logic [21:0] v;
         v = VEC[i];
         load_lock(v[21:19]);
         check_perm(v[21:19]);
         rd_req = 1'b1; rd_verify = v[18]; rd_pc_ext = v[17]; flash_rdata = v[16:9];
         @(negedge clk);
         rd_req = 1'b0; flash_rdata = 8'h00;
         check("R8 rd_valid", int'(rd_valid), 1);
         check("R8 rd_data", int'(rd_data), int'(v[8:1]));
         check("R8 rd_violation", int'(rd_violation), int'(v[0]));
         @(negedge clk);
         check("R8 violation one cycle", int'(rd_violation), 0);
         check("R8 valid drops", int'(rd_valid), 0);
      end

      // R1: reset loads nonvolatile copy
      do_reset(3'b101, 1'b1);
      check("R1 level from nv", int'(lock_level), 3);
      check("R9 captured ea", int'(ea_eff), 1);
      ea_pin = 1'b0;
      #1;
      check("R9 ea held after pin moves", int'(ea_eff), 1);
      check("R10 mismatch raised", int'(ea_mismatch), 1);
      ea_pin = 1'b1;
      #1;
      check("R10 mismatch clears", int'(ea_mismatch), 0);

      // R2: clearing write ignored, set write accumulates
      do_reset(3'b000, 1'b0);
      @(negedge clk);
      lock_wr_en = 1'b1; lock_wr_data = 3'b010;
      @(negedge clk);
      lock_wr_data = 3'b000;
      @(negedge clk);
      lock_wr_en = 1'b0;
      check("R2 zero write keeps bit", int'(lock_level), 2);
      lock_wr_en = 1'b1; lock_wr_data = 3'b001;
      @(negedge clk);
      lock_wr_en = 1'b0; lock_wr_data = 3'b000;
      check("R2 bits accumulate level", int'(lock_level), 2);
      check("R2 prog blocked", int'(prog_allow), 0);

      // R3: erase beats a write in the same cycle
      chip_erase = 1'b1; lock_wr_en = 1'b1; lock_wr_data = 3'b111;
      @(negedge clk);
      chip_erase = 1'b0; lock_wr_en = 1'b0; lock_wr_data = 3'b000;
      check("R3 erase priority", int'(lock_level), 0);
      check("R3 prog restored", int'(prog_allow), 1);

      // R9: no capture without bit 0 at reset, even if programmed later
      do_reset(3'b000, 1'b1);
      lock_wr_en = 1'b1; lock_wr_data = 3'b001;
      @(negedge clk);
      lock_wr_en = 1'b0; lock_wr_data = 3'b000;
      ea_pin = 1'b0;
      #1;
      check("R9 ea follows pin", int'(ea_eff), 0);
      check("R10 no mismatch without capture", int'(ea_mismatch), 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule